// File: doc/BRIEF.md
# System Configuration Register Bank

This block is a small bank of 32-bit control registers on a simple memory-mapped bus with separate read and write strobes, a byte address and byte-lane write enables. It holds the settings that steer chip-level plumbing: which memory is visible at address zero, whether a processor lockup is routed to the timer break input, a sticky lock that routes the supply-monitor interrupt to the same break input and freezes the supply-monitor settings held in another block, the power control of the I/O compensation cell, two drive-force bits for fast-mode-plus pads, and one spare peripheral mode bit.

Every stored setting is driven out as a static control level. The compensation cell's ready status comes in asynchronously and is resynchronised before software can read it. The memory-select field does not reset to a constant: while reset is held it follows the boot-mode pins, so the part starts from the memory those pins chose.

Read data is registered: a read strobe captures the addressed word on the clock edge, and the value stays on the read bus until the next read.

Top module: `sys_cfg_bank`

## Requirements
- R1: While reset is held, the memory-select field and `remap_sel_o` take the value on `boot_mode_i`; every other stored setting is 0.
- R2: The 2-bit memory-select field at bits 1:0 of word offset 0x00 is written and read back as written, including the reserved code 2'b10 (codes: 00 main flash, 01 system flash, 11 on-chip SRAM).
- R3: A write changes only the fields whose byte lane has its `bus_be_i` bit set (bits 7:0 on lane 0, bits 23:16 on lane 2).
- R4: Bit 2 of offset 0x1C is a lock: writing 1 sets it, writing 0 leaves it set, and only reset clears it; while set, `brk_mon_en_o` and `mon_cfg_wp_o` are 1.
- R5: Bit 0 of offset 0x1C can be set and cleared at will and drives `brk_lockup_en_o`.
- R6: Bit 0 of offset 0x20 drives `cell_en_o` (1 = cell enabled, 0 = powered down).
- R7: Bit 8 of offset 0x20 shows `cell_ready_i` through a two-flop synchronizer: a read whose capture edge is the third rising edge after the input changes shows the new value; reads captured on the first two edges show the old one.
- R8: Writes to the ready bit (bit 8 of 0x20) have no effect on what is read there.
- R9: At offset 0x2C, bit 0 drives `fmp_scl_o` and bit 1 drives `fmp_sda_o`.
- R10: Bit 16 of offset 0x04 is a read/write bit, reset 0, that drives `pmode_ctl_o`.
- R11: Unused bits of mapped words read 0 and ignore writes; reads of unmapped offsets return 0 and writes to them change nothing.
- R12: `bus_rdata_o` is loaded on the clock edge that samples `bus_rd_i` high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_mode_i | input | 2 | Boot-mode pins; reset value of the memory-select field |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata_i | input | DATA_W | Write data |
| bus_be_i | input | DATA_W/8 | Byte-lane write enables |
| bus_rdata_o | output | DATA_W | Registered read data |
| cell_ready_i | input | 1 | Asynchronous ready status from the compensation cell |
| remap_sel_o | output | 2 | Memory selected at address zero |
| pmode_ctl_o | output | 1 | Peripheral mode control bit |
| brk_mon_en_o | output | 1 | Supply-monitor interrupt routed to timer break |
| mon_cfg_wp_o | output | 1 | Write protect for the supply-monitor settings |
| brk_lockup_en_o | output | 1 | Processor lockup routed to timer break |
| cell_en_o | output | 1 | Compensation cell enable |
| fmp_scl_o | output | 1 | Force fast-mode-plus drive on the clock pad |
| fmp_sda_o | output | 1 | Force fast-mode-plus drive on the data pad |

## Verification
The hardest situation to reach from the ports is the exact visibility edge of the ready flag, since it depends on when the asynchronous input lands relative to the read. The stimulus changes `cell_ready_i` and asserts a continuous read of the compensation word in the same cycle, then inspects three back-to-back captures to pin the two-cycle delay. The lock's stickiness is reached by writing zero, all ones without bit 2 and a lockup-only pattern after it is set, and then a second reset with different boot pins proves that only reset releases it and reloads the memory select.

// File: rtl/sys_cfg_pkg.sv
`timescale 1ns/1ps
// Shared offsets, field positions and types for the system configuration bank.
// Assumes word-aligned byte addresses; field positions are fixed by the map.
package sys_cfg_pkg;

    localparam int OFS_REMAP = 'h00;
    localparam int OFS_PMODE = 'h04;
    localparam int OFS_CFG2  = 'h1C;
    localparam int OFS_COMP  = 'h20;
    localparam int OFS_DRIVE = 'h2C;

    localparam int PMODE_BIT  = 16;
    localparam int LOCKUP_BIT = 0;
    localparam int LOCK_BIT   = 2;
    localparam int CELL_BIT   = 0;
    localparam int READY_BIT  = 8;
    localparam int SCL_BIT    = 0;
    localparam int SDA_BIT    = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_REMAP,
        SEL_PMODE,
        SEL_CFG2,
        SEL_COMP,
        SEL_DRIVE
    } reg_sel_t;

    typedef struct packed {
        logic [1:0] remap;
        logic       pmode;
        logic       lock;
        logic       lockup;
        logic       cell_en;
        logic       fmp_scl;
        logic       fmp_sda;
    } cfg_t;

endpackage

// File: rtl/sys_cfg_decode.sv
`timescale 1ns/1ps
// Address decoder: maps the word part of a byte address onto a register
// select. Assumes ADDR_W is wide enough to hold the highest offset.
module sys_cfg_decode
    import sys_cfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);
    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] WA_REMAP = WA_W'(OFS_REMAP >> 2);
    localparam logic [WA_W-1:0] WA_PMODE = WA_W'(OFS_PMODE >> 2);
    localparam logic [WA_W-1:0] WA_CFG2  = WA_W'(OFS_CFG2 >> 2);
    localparam logic [WA_W-1:0] WA_COMP  = WA_W'(OFS_COMP >> 2);
    localparam logic [WA_W-1:0] WA_DRIVE = WA_W'(OFS_DRIVE >> 2);

    logic [WA_W-1:0] word_idx;
    logic [1:0]      unused_byte_bits;

    assign word_idx         = addr_i[ADDR_W-1:2];
    assign unused_byte_bits = addr_i[1:0];

    // Purpose: pick the register addressed by the word index.
    always_comb begin
        if (word_idx == WA_REMAP)      sel_o = SEL_REMAP;
        else if (word_idx == WA_PMODE) sel_o = SEL_PMODE;
        else if (word_idx == WA_CFG2)  sel_o = SEL_CFG2;
        else if (word_idx == WA_COMP)  sel_o = SEL_COMP;
        else if (word_idx == WA_DRIVE) sel_o = SEL_DRIVE;
        else                           sel_o = SEL_NONE;
    end

endmodule

// File: rtl/sys_cfg_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for a single asynchronous level.
// Assumes STAGES >= 2; output resets to 0.
module sys_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Purpose: shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/sys_cfg_regs.sv
`timescale 1ns/1ps
// Storage for all writable settings. Applies byte-lane enables, keeps the
// lock sticky until reset, and loads the memory select from the boot pins
// while reset is held. Assumes DATA_W >= 24.
module sys_cfg_regs
    import sys_cfg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        boot_mode_i,
    input  logic              wr_i,
    input  reg_sel_t          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W/8-1:0] be_i,
    output cfg_t              cfg_o
);
    localparam int LN_REMAP = 0;
    localparam int LN_PMODE = PMODE_BIT / 8;
    localparam int LN_CFG2  = LOCK_BIT / 8;
    localparam int LN_COMP  = CELL_BIT / 8;
    localparam int LN_DRIVE = SDA_BIT / 8;

    cfg_t cfg;
    logic unused_wdata;

    assign unused_wdata = ^{wdata_i, be_i};

    // Purpose: reset, then update the selected register from enabled lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg       <= '0;
            cfg.remap <= boot_mode_i;
        end else if (wr_i) begin
            case (sel_i)
                SEL_REMAP: if (be_i[LN_REMAP]) cfg.remap <= wdata_i[1:0];
                SEL_PMODE: if (be_i[LN_PMODE]) cfg.pmode <= wdata_i[PMODE_BIT];
                SEL_CFG2: if (be_i[LN_CFG2]) begin
                    cfg.lockup <= wdata_i[LOCKUP_BIT];
                    if (wdata_i[LOCK_BIT]) cfg.lock <= 1'b1;
                end
                SEL_COMP:  if (be_i[LN_COMP]) cfg.cell_en <= wdata_i[CELL_BIT];
                SEL_DRIVE: if (be_i[LN_DRIVE]) begin
                    cfg.fmp_scl <= wdata_i[SCL_BIT];
                    cfg.fmp_sda <= wdata_i[SDA_BIT];
                end
                default: ;
            endcase
        end
    end

    assign cfg_o = cfg;

endmodule

// File: rtl/sys_cfg_rdmux.sv
`timescale 1ns/1ps
// Read-word assembly: places each stored field and the synchronised ready
// flag at its bit position; all other bits and unmapped words are zero.
module sys_cfg_rdmux
    import sys_cfg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  reg_sel_t          sel_i,
    input  cfg_t              cfg_i,
    input  logic              ready_i,
    output logic [DATA_W-1:0] word_o
);
    // Purpose: build the word for the selected register.
    always_comb begin
        word_o = '0;
        case (sel_i)
            SEL_REMAP: word_o[1:0] = cfg_i.remap;
            SEL_PMODE: word_o[PMODE_BIT] = cfg_i.pmode;
            SEL_CFG2: begin
                word_o[LOCKUP_BIT] = cfg_i.lockup;
                word_o[LOCK_BIT]   = cfg_i.lock;
            end
            SEL_COMP: begin
                word_o[CELL_BIT]  = cfg_i.cell_en;
                word_o[READY_BIT] = ready_i;
            end
            SEL_DRIVE: begin
                word_o[SCL_BIT] = cfg_i.fmp_scl;
                word_o[SDA_BIT] = cfg_i.fmp_sda;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sys_cfg_bank.sv
`timescale 1ns/1ps
// System configuration register bank top. Decodes the bus, holds settings,
// resynchronises the cell ready flag and registers read data.
// Assumes a single clock domain for the bus and all control outputs.
module sys_cfg_bank
    import sys_cfg_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          boot_mode_i,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    input  logic [DATA_W/8-1:0] bus_be_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    input  logic                cell_ready_i,
    output logic [1:0]          remap_sel_o,
    output logic                pmode_ctl_o,
    output logic                brk_mon_en_o,
    output logic                mon_cfg_wp_o,
    output logic                brk_lockup_en_o,
    output logic                cell_en_o,
    output logic                fmp_scl_o,
    output logic                fmp_sda_o
);
    reg_sel_t          sel;
    cfg_t              cfg;
    logic              ready_s;
    logic [DATA_W-1:0] rd_word;

    sys_cfg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    sys_cfg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_mode_i (boot_mode_i),
        .wr_i        (bus_wr_i),
        .sel_i       (sel),
        .wdata_i     (bus_wdata_i),
        .be_i        (bus_be_i),
        .cfg_o       (cfg)
    );

    sys_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cell_ready_i),
        .q_o   (ready_s)
    );

    sys_cfg_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .sel_i   (sel),
        .cfg_i   (cfg),
        .ready_i (ready_s),
        .word_o  (rd_word)
    );

    // Purpose: capture the addressed word on a read strobe and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= rd_word;
    end

    assign remap_sel_o     = cfg.remap;
    assign pmode_ctl_o     = cfg.pmode;
    assign brk_mon_en_o    = cfg.lock;
    assign mon_cfg_wp_o    = cfg.lock;
    assign brk_lockup_en_o = cfg.lockup;
    assign cell_en_o       = cfg.cell_en;
    assign fmp_scl_o       = cfg.fmp_scl;
    assign fmp_sda_o       = cfg.fmp_sda;

endmodule

// File: rtl/sys_cfg_bank_chk.sv
`timescale 1ns/1ps
// Property checker for sys_cfg_bank, attached by bind. A saturating counter
// gates every check until enough cycles have passed since reset.
module sys_cfg_bank_chk
    import sys_cfg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr_i,
    input logic                bus_rd_i,
    input logic [ADDR_W-1:0]   bus_addr_i,
    input logic [DATA_W-1:0]   bus_wdata_i,
    input logic [DATA_W/8-1:0] bus_be_i,
    input logic [DATA_W-1:0]   bus_rdata_o,
    input logic                cell_ready_i,
    input logic [1:0]          remap_sel_o,
    input logic                brk_mon_en_o,
    input logic                mon_cfg_wp_o,
    input logic                brk_lockup_en_o,
    input logic                cell_en_o
);
    localparam int WA_W = ADDR_W - 2;
    logic [WA_W-1:0] wa;
    logic [2:0]      since_rst;
    logic            warm;
    logic            hit_remap, hit_cfg2, hit_comp, hit_any;

    assign wa        = bus_addr_i[ADDR_W-1:2];
    assign hit_remap = (wa == WA_W'(OFS_REMAP >> 2));
    assign hit_cfg2  = (wa == WA_W'(OFS_CFG2 >> 2));
    assign hit_comp  = (wa == WA_W'(OFS_COMP >> 2));
    assign hit_any   = hit_remap || hit_cfg2 || hit_comp ||
                       (wa == WA_W'(OFS_PMODE >> 2)) || (wa == WA_W'(OFS_DRIVE >> 2));
    assign warm      = (since_rst >= 3'd4);

    // Purpose: count cycles since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)     since_rst <= '0;
        else if (!warm) since_rst <= since_rst + 3'd1;
    end

    // R2
    remap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !(bus_wr_i && hit_remap && bus_be_i[0])) |=> $stable(remap_sel_o));

    // R4
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && brk_mon_en_o) |=> (brk_mon_en_o && mon_cfg_wp_o));

    // R4
    lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $rose(brk_mon_en_o)) |->
            $past(bus_wr_i && hit_cfg2 && bus_be_i[0] && bus_wdata_i[LOCK_BIT]));

    // R5
    lockup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !(bus_wr_i && hit_cfg2 && bus_be_i[0])) |=> $stable(brk_lockup_en_o));

    // R6
    cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !(bus_wr_i && hit_comp && bus_be_i[0])) |=> $stable(cell_en_o));

    // R7
    ready_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && bus_rd_i && hit_comp) |=> (bus_rdata_o[READY_BIT] == $past(cell_ready_i, 3)));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && bus_rd_i && !hit_any) |=> (bus_rdata_o == '0));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !bus_rd_i) |=> $stable(bus_rdata_o));

endmodule

bind sys_cfg_bank sys_cfg_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sys_cfg_bank_tb.sv
`timescale 1ns/1ps
module sys_cfg_bank_tb;

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 32'h0000_0003, 4'h1, 32'h0000_0003, 4'd2},  // R2 SRAM code
        '{8'h00, 32'h0000_0002, 4'h1, 32'h0000_0002, 4'd2},  // R2 reserved code kept
        '{8'h00, 32'h0000_0000, 4'hE, 32'h0000_0002, 4'd3},  // R3 lane 0 off
        '{8'h04, 32'hFFFF_FFFF, 4'hF, 32'h0001_0000, 4'd10}, // R10 R11
        '{8'h04, 32'h0000_0000, 4'hB, 32'h0001_0000, 4'd3},  // R3 lane 2 off
        '{8'h04, 32'h0000_0000, 4'h4, 32'h0000_0000, 4'd10}, // R10 clear
        '{8'h1C, 32'h0000_0001, 4'h1, 32'h0000_0001, 4'd5},  // R5 set
        '{8'h1C, 32'h0000_0000, 4'h1, 32'h0000_0000, 4'd5},  // R5 clear
        '{8'h20, 32'h0000_0101, 4'h3, 32'h0000_0001, 4'd8},  // R8 R6
        '{8'h2C, 32'h0000_0003, 4'h1, 32'h0000_0003, 4'd9},  // R9 both
        '{8'h2C, 32'hFFFF_FFFC, 4'hF, 32'h0000_0000, 4'd11}, // R11 reserved bits
        '{8'h08, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, 4'd11}, // R11 unmapped
        '{8'h2C, 32'h0000_0002, 4'h1, 32'h0000_0002, 4'd9}   // R9 data pad only
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  boot_mode;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_be;
    logic [31:0] bus_rdata;
    logic        cell_ready;
    logic [1:0]  remap_sel;
    logic        pmode_ctl, brk_mon_en, mon_cfg_wp, brk_lockup_en, cell_en, fmp_scl, fmp_sda;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    sys_cfg_bank u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .boot_mode_i     (boot_mode),
        .bus_wr_i        (bus_wr),
        .bus_rd_i        (bus_rd),
        .bus_addr_i      (bus_addr),
        .bus_wdata_i     (bus_wdata),
        .bus_be_i        (bus_be),
        .bus_rdata_o     (bus_rdata),
        .cell_ready_i    (cell_ready),
        .remap_sel_o     (remap_sel),
        .pmode_ctl_o     (pmode_ctl),
        .brk_mon_en_o    (brk_mon_en),
        .mon_cfg_wp_o    (mon_cfg_wp),
        .brk_lockup_en_o (brk_lockup_en),
        .cell_en_o       (cell_en),
        .fmp_scl_o       (fmp_scl),
        .fmp_sda_o       (fmp_sda)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic apply_reset(input logic [1:0] boot);
        @(negedge clk);
        rst_n = 1'b0; boot_mode = boot;
        repeat (3) @(negedge clk);
        check("R1 remap during reset", {30'd0, remap_sel}, {30'd0, boot});
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; boot_mode = 2'b01; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0; bus_be = '0; cell_ready = 1'b0;

        // R1: reset state follows boot pins, rest cleared
        apply_reset(2'b01);
        bus_read(8'h00, rd); check("R1 remap read", rd, 32'h1);
        check("R1 outputs zero",
              {24'd0, pmode_ctl, brk_mon_en, mon_cfg_wp, brk_lockup_en, cell_en, fmp_scl, fmp_sda, 1'b0},
              32'h0);
        bus_read(8'h1C, rd); check("R1 cfg2 zero", rd, 32'h0);

        // Table: write then read back
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VECS[i].addr, VECS[i].wdata, VECS[i].be);
            bus_read(VECS[i].addr, rd);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
        end

        // R2 R6 R9 R10: outputs after the table
        check("R2 remap_sel_o", {30'd0, remap_sel}, 32'h2);
        check("R6 cell_en_o", {31'd0, cell_en}, 32'h1);
        check("R9 pad outputs", {30'd0, fmp_sda, fmp_scl}, 32'h2);
        check("R10 pmode_ctl_o", {31'd0, pmode_ctl}, 32'h0);

        // R4: lock sets, resists clearing
        bus_write(8'h1C, 32'h4, 4'h1);
        bus_read(8'h1C, rd); check("R4 lock set", rd, 32'h4);
        check("R4 lock outputs", {30'd0, brk_mon_en, mon_cfg_wp}, 32'h3);
        bus_write(8'h1C, 32'hFFFF_FFFB, 4'hF);
        bus_read(8'h1C, rd); check("R4 lock kept, R5 lockup set", rd, 32'h5);
        check("R5 brk_lockup_en_o", {31'd0, brk_lockup_en}, 32'h1);
        bus_write(8'h1C, 32'h0, 4'hF);
        bus_read(8'h1C, rd); check("R4 lock survives zero write", rd, 32'h4);
        check("R4 wp stays", {30'd0, brk_mon_en, mon_cfg_wp}, 32'h3);

        // R7: ready visible on the third capture edge
        @(negedge clk);
        cell_ready = 1'b1; bus_rd = 1'b1; bus_addr = 8'h20;
        @(negedge clk); check("R7 capture 1", {31'd0, bus_rdata[8]}, 32'h0);
        @(negedge clk); check("R7 capture 2", {31'd0, bus_rdata[8]}, 32'h0);
        @(negedge clk); check("R7 capture 3", {31'd0, bus_rdata[8]}, 32'h1);
        bus_rd = 1'b0;

        // R8: writing zero to ready leaves it; cell disabled
        bus_write(8'h20, 32'h0, 4'hF);
        bus_read(8'h20, rd); check("R8 ready unchanged", rd, 32'h100);
        check("R6 cell powered down", {31'd0, cell_en}, 32'h0);

        // R12: read data held without a read strobe
        @(negedge clk); bus_addr = 8'h00;
        repeat (3) @(negedge clk);
        check("R12 rdata hold", bus_rdata, 32'h100);

        // R4 R1: only reset clears lock; boot pins reload
        cell_ready = 1'b0;
        apply_reset(2'b11);
        check("R4 lock cleared by reset", {30'd0, brk_mon_en, mon_cfg_wp}, 32'h0);
        bus_read(8'h00, rd); check("R1 remap from new boot value", rd, 32'h3);
        bus_read(8'h1C, rd); check("R4 cfg2 after reset", rd, 32'h0);
        bus_read(8'h20, rd); check("R1 comp after reset", rd, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule